// File: doc/BRIEF.md
# Serial Link Request Decoder

This block sits on the physical-layer side of a link/physical-layer pair. It watches a single request line that idles low. A 1 on that line starts a frame. The three bits after the start bit give the request type, and the type sets how many more bits the decoder collects. Once a frame is complete, the block acts on it at once. It can hold one bus request (immediate, isochronous, priority or fair) together with its speed code. It can write a register in a small local register file, or set up a register read that is returned through a status transfer. It can also change the arbitration-acceleration enable.

The surrounding logic reports bus events on a few single-cycle inputs: arbitration won, arbitration lost, bus reset, a two-bit interface control state (10b means receive) and a status-transfer-done strobe. The block applies the clearing and ignoring rules for pending requests. When a bus request carries an unsupported speed code, it raises a flag that asks for a null packet in place of link data. Frames that cannot be parsed are dropped and reported with a one-cycle error pulse.

Top module: `linkreq_decoder`

## Requirements
- R1: With the line at 0 the decoder stays idle. A 1 starts a frame and bits follow one per clock, most significant first: the start bit, then a 3-bit type (000 immediate, 001 isochronous, 010 priority, 011 fair, 100 register read, 101 register write, 110 acceleration control, 111 invalid), then the fields of that type. A frame's effect is visible on the outputs two clocks after its last bit is sampled.
- R2: A bus-request frame is start, type, then a 3-bit speed code. If the last speed bit is 0, the frame ends after those 7 bits. Otherwise it ends with a stop bit of 0. An accepted request drives bus_pend=1, bus_kind=type[1:0] and bus_speed=speed code.
- R3: A speed code other than 000, 010 or 100 is still accepted as a bus request, and null_pkt is 1 while that request is pending. null_pkt is 0 whenever no request is pending.
- R4: Only one bus request is held at a time. A bus request that arrives while one is pending is ignored. A pending request is cleared by bus_won, by bus_lost (for any kind except isochronous) and by bus_reset.
- R5: ctl_state=10b clears a pending priority or fair request. A priority or fair request is ignored if ctl_state=10b during any cycle of its frame.
- R6: A pending isochronous request is cleared only by bus_won or bus_reset. bus_lost and the receive state leave it pending.
- R7: A register-write frame (start, 101, 4-bit address, 8-bit data, stop 0) updates the addressed register as soon as the frame ends.
- R8: A register-read frame (start, 100, 4-bit address, stop 0) sets stat_pend and latches stat_addr, and stat_data shows that register. The flag stays set across bus_reset and across interrupted transfers until stat_done. Reads that arrive while it is set are ignored.
- R9: An acceleration frame (start, 110, control bit, stop 0) sets accel_en to the control bit right away. When eaa_cfg=1, bus_reset or an isochronous request frame sets accel_en to 1. When eaa_cfg=0, neither of them changes it. accel_en is 0 after reset.
- R10: A frame with type 111, or with a stop bit of 1, has no effect and raises frame_err for one cycle.
- R11: Register reads and writes leave a pending bus request, its kind and its speed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_line | input | 1 | Serial request line, idles low |
| ctl_state | input | 2 | Interface control state, 10b = receive |
| bus_won | input | 1 | Arbitration won, one-cycle strobe |
| bus_lost | input | 1 | Arbitration lost, one-cycle strobe |
| bus_reset | input | 1 | Bus reset, one-cycle strobe |
| eaa_cfg | input | 1 | Acceleration configuration enable |
| stat_done | input | 1 | Status transfer completed |
| bus_pend | output | 1 | A bus request is pending |
| bus_kind | output | 2 | Kind of the pending request |
| bus_speed | output | 3 | Speed code of the pending request |
| null_pkt | output | 1 | Pending request needs a null packet |
| stat_pend | output | 1 | Register-read status transfer pending |
| stat_addr | output | 4 | Address of the pending read |
| stat_data | output | 8 | Contents of the register being read |
| accel_en | output | 1 | Arbitration acceleration enabled |
| frame_err | output | 1 | Malformed frame pulse |

## Verification
Any error in frame length or field alignment shows up two clocks after the last bit. It appears as a wrong bus_speed or stat_addr, a register whose value reads back wrong, or a frame_err pulse where none should be. A wrong clearing rule leaves bus_pend or stat_pend at the wrong value on the cycle after the event strobe. The next request frame then exposes it, because that frame is accepted or ignored against the model's expectation. A stale acceleration state is visible on accel_en one clock after the bus reset or frame that should have changed it.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
   typedef enum logic [2:0] {
      RQ_IMM  = 3'b000,
      RQ_ISO  = 3'b001,
      RQ_PRI  = 3'b010,
      RQ_FAIR = 3'b011,
      RQ_RD   = 3'b100,
      RQ_WR   = 3'b101,
      RQ_ACC  = 3'b110,
      RQ_BAD  = 3'b111
   } req_kind_e;

   function automatic logic speed_ok(input logic [2:0] sp);
      return (sp == 3'b000) || (sp == 3'b010) || (sp == 3'b100);
   endfunction

   function automatic logic is_bus(input req_kind_e k);
      return k[2] == 1'b0;
   endfunction
endpackage

// File: rtl/lrd_deser.sv
module lrd_deser
   import lrd_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line,
   input  logic              rx_active,
   output logic              f_valid,
   output logic              f_err,
   output req_kind_e         f_kind,
   output logic [2:0]        f_speed,
   output logic [ADDR_W-1:0] f_addr,
   output logic [DATA_W-1:0] f_data,
   output logic              f_ctrl,
   output logic              f_rxhit
);
   localparam int SR_W    = ADDR_W + DATA_W;
   localparam int RD_LAST = ADDR_W + 4;
   localparam int WR_LAST = ADDR_W + DATA_W + 4;
   localparam int CNT_W   = $clog2(WR_LAST + 1);
   localparam logic [CNT_W-1:0] IDX_TYPE = CNT_W'(3);
   localparam logic [CNT_W-1:0] IDX_ACC  = CNT_W'(5);
   localparam logic [CNT_W-1:0] IDX_B7   = CNT_W'(6);
   localparam logic [CNT_W-1:0] IDX_B8   = CNT_W'(7);
   localparam logic [CNT_W-1:0] IDX_RD   = CNT_W'(RD_LAST);
   localparam logic [CNT_W-1:0] IDX_WR   = CNT_W'(WR_LAST);

   if (ADDR_W < 1 || DATA_W < 1 || SR_W < 3) begin : g_bad_width
      $error("lrd_deser: field widths too small");
   end

   logic              busy;
   logic [CNT_W-1:0]  idx;
   logic [SR_W-1:0]   sr;
   req_kind_e         kind;
   logic              rxh;
   logic [SR_W:0]     cur;
   logic              fin, bad;

   always_comb begin
      cur = {sr, line};
      fin = 1'b0;
      bad = 1'b0;
      if (busy) begin
         if (idx == IDX_TYPE) begin
            bad = (cur[2:0] == 3'b111);
         end else if (idx > IDX_TYPE) begin
            case (kind)
               RQ_IMM, RQ_ISO, RQ_PRI, RQ_FAIR: begin
                  if (idx == IDX_B7 && !line) fin = 1'b1;
                  else if (idx == IDX_B8) begin
                     fin = !line;
                     bad = line;
                  end
               end
               RQ_RD: if (idx == IDX_RD) begin
                  fin = !line;
                  bad = line;
               end
               RQ_WR: if (idx == IDX_WR) begin
                  fin = !line;
                  bad = line;
               end
               RQ_ACC: if (idx == IDX_ACC) begin
                  fin = !line;
                  bad = line;
               end
               default: bad = 1'b1;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         sr      <= '0;
         kind    <= RQ_IMM;
         rxh     <= 1'b0;
         f_valid <= 1'b0;
         f_err   <= 1'b0;
         f_kind  <= RQ_IMM;
         f_speed <= '0;
         f_addr  <= '0;
         f_data  <= '0;
         f_ctrl  <= 1'b0;
         f_rxhit <= 1'b0;
      end else begin
         f_valid <= fin;
         f_err   <= bad;
         if (!busy) begin
            if (line) begin
               busy <= 1'b1;
               idx  <= CNT_W'(1);
               sr   <= '0;
               rxh  <= rx_active;
            end
         end else begin
            sr  <= cur[SR_W-1:0];
            idx <= idx + CNT_W'(1);
            rxh <= rxh | rx_active;
            if (idx == IDX_TYPE) kind <= req_kind_e'(cur[2:0]);
            if (fin || bad) busy <= 1'b0;
         end
         if (fin) begin
            f_kind  <= kind;
            f_speed <= (idx == IDX_B7) ? cur[2:0] : cur[3:1];
            f_addr  <= (kind == RQ_WR) ? cur[SR_W:DATA_W+1] : cur[ADDR_W:1];
            f_data  <= cur[DATA_W:1];
            f_ctrl  <= cur[1];
            f_rxhit <= rxh | rx_active;
         end
      end
   end
endmodule

// File: rtl/lrd_bus_track.sv
module lrd_bus_track
   import lrd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       f_valid,
   input  req_kind_e  f_kind,
   input  logic [2:0] f_speed,
   input  logic       f_rxhit,
   input  logic       rx_active,
   input  logic       bus_won,
   input  logic       bus_lost,
   input  logic       bus_reset,
   output logic       pend,
   output logic [1:0] kind,
   output logic [2:0] speed,
   output logic       null_pkt
);
   logic null_r;
   logic rx_block;

   assign rx_block = f_kind[1] && (f_rxhit || rx_active);
   assign null_pkt = pend && null_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         kind   <= 2'b00;
         speed  <= 3'b000;
         null_r <= 1'b0;
      end else if (bus_reset) begin
         pend <= 1'b0;
      end else if (pend) begin
         if (bus_won) pend <= 1'b0;
         else if (bus_lost && kind != RQ_ISO[1:0]) pend <= 1'b0;
         else if (rx_active && kind[1]) pend <= 1'b0;
      end else if (f_valid && is_bus(f_kind) && !rx_block) begin
         pend   <= 1'b1;
         kind   <= f_kind[1:0];
         speed  <= f_speed;
         null_r <= !speed_ok(f_speed);
      end
   end
endmodule

// File: rtl/lrd_regs.sv
module lrd_regs #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              stat_done,
   output logic              stat_pend,
   output logic [ADDR_W-1:0] stat_addr,
   output logic [DATA_W-1:0] stat_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DEPTH > 4096) begin : g_bad_depth
      $error("lrd_regs: register file too deep");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) mem[g] <= '0;
         else if (wr_en && addr == ADDR_W'(g)) mem[g] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_pend <= 1'b0;
         stat_addr <= '0;
      end else if (stat_done) begin
         stat_pend <= 1'b0;
      end else if (rd_en && !stat_pend) begin
         stat_pend <= 1'b1;
         stat_addr <= addr;
      end
   end

   assign stat_data = mem[stat_addr];
endmodule

// File: rtl/linkreq_decoder.sv
module linkreq_decoder
   import lrd_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_line,
   input  logic [1:0]        ctl_state,
   input  logic              bus_won,
   input  logic              bus_lost,
   input  logic              bus_reset,
   input  logic              eaa_cfg,
   input  logic              stat_done,
   output logic              bus_pend,
   output logic [1:0]        bus_kind,
   output logic [2:0]        bus_speed,
   output logic              null_pkt,
   output logic              stat_pend,
   output logic [ADDR_W-1:0] stat_addr,
   output logic [DATA_W-1:0] stat_data,
   output logic              accel_en,
   output logic              frame_err
);
   logic              rx_active;
   logic              f_valid, f_ctrl, f_rxhit;
   req_kind_e         f_kind;
   logic [2:0]        f_speed;
   logic [ADDR_W-1:0] f_addr;
   logic [DATA_W-1:0] f_data;

   assign rx_active = (ctl_state == 2'b10);

   lrd_deser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_deser (
      .clk(clk), .rst_n(rst_n), .line(req_line), .rx_active(rx_active),
      .f_valid(f_valid), .f_err(frame_err), .f_kind(f_kind), .f_speed(f_speed),
      .f_addr(f_addr), .f_data(f_data), .f_ctrl(f_ctrl), .f_rxhit(f_rxhit)
   );

   lrd_bus_track i_track (
      .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_kind(f_kind),
      .f_speed(f_speed), .f_rxhit(f_rxhit), .rx_active(rx_active),
      .bus_won(bus_won), .bus_lost(bus_lost), .bus_reset(bus_reset),
      .pend(bus_pend), .kind(bus_kind), .speed(bus_speed), .null_pkt(null_pkt)
   );

   lrd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(f_valid && f_kind == RQ_WR), .rd_en(f_valid && f_kind == RQ_RD),
      .addr(f_addr), .wdata(f_data), .stat_done(stat_done),
      .stat_pend(stat_pend), .stat_addr(stat_addr), .stat_data(stat_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         accel_en <= 1'b0;
      end else begin
         if (f_valid && f_kind == RQ_ACC) accel_en <= f_ctrl;
         if (eaa_cfg && (bus_reset || (f_valid && f_kind == RQ_ISO))) accel_en <= 1'b1;
      end
   end
endmodule

// File: rtl/lrd_checker.sv
module lrd_checker #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        ctl_state,
   input logic              bus_won,
   input logic              bus_lost,
   input logic              bus_reset,
   input logic              eaa_cfg,
   input logic              stat_done,
   input logic              bus_pend,
   input logic [1:0]        bus_kind,
   input logic              null_pkt,
   input logic              stat_pend,
   input logic [ADDR_W-1:0] stat_addr,
   input logic              accel_en
);
   logic rx;
   assign rx = (ctl_state == 2'b10);

   p_null_needs_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_pend |-> !null_pkt);

   p_pend_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_pend && !bus_won && !bus_lost && !bus_reset && !rx
      |=> bus_pend && $stable(bus_kind));

   p_reset_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !bus_pend);

   p_rx_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_pend && bus_kind[1] && rx && !bus_reset |=> !bus_pend);

   p_iso_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_pend && bus_kind == 2'b01 && !bus_won && !bus_reset |=> bus_pend);

   p_stat_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_pend && !stat_done |=> stat_pend && $stable(stat_addr));

   p_accel_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset && eaa_cfg |=> accel_en);
endmodule

bind linkreq_decoder lrd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .ctl_state(ctl_state), .bus_won(bus_won),
   .bus_lost(bus_lost), .bus_reset(bus_reset), .eaa_cfg(eaa_cfg),
   .stat_done(stat_done), .bus_pend(bus_pend), .bus_kind(bus_kind),
   .null_pkt(null_pkt), .stat_pend(stat_pend), .stat_addr(stat_addr),
   .accel_en(accel_en)
);

// File: tb/test_linkreq_decoder.sv
module test_linkreq_decoder;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_line;
   logic [1:0] ctl_state;
   logic       bus_won, bus_lost, bus_reset, eaa_cfg, stat_done;
   logic       bus_pend, null_pkt, stat_pend, accel_en, frame_err;
   logic [1:0] bus_kind;
   logic [2:0] bus_speed;
   logic [3:0] stat_addr;
   logic [7:0] stat_data;

   int n_chk = 0;
   int n_fail = 0;

   logic       m_pend, m_null, m_stat, m_acc;
   logic [1:0] m_kind;
   logic [2:0] m_speed;
   logic [3:0] m_saddr;
   logic [7:0] m_regs [16];

   always #5 clk = ~clk;

   linkreq_decoder i_linkreq_decoder (
      .clk(clk), .rst_n(rst_n), .req_line(req_line), .ctl_state(ctl_state),
      .bus_won(bus_won), .bus_lost(bus_lost), .bus_reset(bus_reset),
      .eaa_cfg(eaa_cfg), .stat_done(stat_done), .bus_pend(bus_pend),
      .bus_kind(bus_kind), .bus_speed(bus_speed), .null_pkt(null_pkt),
      .stat_pend(stat_pend), .stat_addr(stat_addr), .stat_data(stat_data),
      .accel_en(accel_en), .frame_err(frame_err)
   );

   function automatic logic spd_ok(input logic [2:0] s);
      return s == 3'b000 || s == 3'b010 || s == 3'b100;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag, input logic exp_err, input logic got_err);
      chk({tag, " frame_err"}, 32'(got_err), 32'(exp_err));
      chk({tag, " bus_pend"}, 32'(bus_pend), 32'(m_pend));
      if (m_pend) begin
         chk({tag, " bus_kind"}, 32'(bus_kind), 32'(m_kind));
         chk({tag, " bus_speed"}, 32'(bus_speed), 32'(m_speed));
      end
      chk({tag, " null_pkt (R3)"}, 32'(null_pkt), 32'(m_pend && m_null));
      chk({tag, " stat_pend"}, 32'(stat_pend), 32'(m_stat));
      if (m_stat) begin
         chk({tag, " stat_addr"}, 32'(stat_addr), 32'(m_saddr));
         chk({tag, " stat_data (R7)"}, 32'(stat_data), 32'(m_regs[m_saddr]));
      end
      chk({tag, " accel_en"}, 32'(accel_en), 32'(m_acc));
   endtask

   // Drives a frame MSB first, one bit per clock, then samples two clocks after the last bit.
   task automatic send(input logic [16:0] bits, input int len, input int rx_at, output logic err);
      for (int i = len - 1; i >= 0; i--) begin
         @(negedge clk);
         req_line  = bits[i];
         ctl_state = (i == rx_at) ? 2'b10 : 2'b00;
      end
      @(posedge clk);
      @(negedge clk);
      req_line  = 1'b0;
      ctl_state = 2'b00;
      err = frame_err;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_req(input logic [2:0] t, input logic [2:0] sp, input bit omit_stop,
                          input int rx_at, input string tag);
      logic e;
      if (sp[0] == 1'b0 && omit_stop) send({10'd0, 1'b1, t, sp}, 7, rx_at, e);
      else send({9'd0, 1'b1, t, sp, 1'b0}, 8, rx_at, e);
      if (!m_pend && !(t[1] && rx_at >= 0)) begin
         m_pend = 1'b1; m_kind = t[1:0]; m_speed = sp; m_null = !spd_ok(sp);
      end
      if (t == 3'b001 && eaa_cfg) m_acc = 1'b1;
      check_all(tag, 1'b0, e);
   endtask

   task automatic rd_req(input logic [3:0] a, input string tag);
      logic e;
      send({8'd0, 1'b1, 3'b100, a, 1'b0}, 9, -1, e);
      if (!m_stat) begin m_stat = 1'b1; m_saddr = a; end
      check_all(tag, 1'b0, e);
   endtask

   task automatic wr_req(input logic [3:0] a, input logic [7:0] d, input bit bad_stop,
                         input string tag);
      logic e;
      send({1'b1, 3'b101, a, d, bad_stop}, 17, -1, e);
      if (!bad_stop) m_regs[a] = d;
      check_all(tag, bad_stop, e);
   endtask

   task automatic acc_req(input logic c, input string tag);
      logic e;
      send({11'd0, 1'b1, 3'b110, c, 1'b0}, 6, -1, e);
      m_acc = c;
      check_all(tag, 1'b0, e);
   endtask

   task automatic bad_type(input string tag);
      logic e;
      send({13'd0, 4'b1111}, 4, -1, e);
      check_all(tag, 1'b1, e);
   endtask

   task automatic ev(input logic w, input logic l, input logic br, input logic rx,
                     input logic dn, input string tag);
      @(negedge clk);
      bus_won = w; bus_lost = l; bus_reset = br; stat_done = dn;
      ctl_state = rx ? 2'b10 : 2'b00;
      @(posedge clk);
      @(negedge clk);
      bus_won = 0; bus_lost = 0; bus_reset = 0; stat_done = 0; ctl_state = 2'b00;
      if (br) begin
         m_pend = 1'b0;
         if (eaa_cfg) m_acc = 1'b1;
      end else if (m_pend) begin
         if (w) m_pend = 1'b0;
         else if (l && m_kind != 2'b01) m_pend = 1'b0;
         else if (rx && m_kind[1]) m_pend = 1'b0;
      end
      if (dn) m_stat = 1'b0;
      check_all(tag, 1'b0, 1'b0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R1: watchdog expired, actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 0; req_line = 0; ctl_state = 2'b00;
      bus_won = 0; bus_lost = 0; bus_reset = 0; eaa_cfg = 1; stat_done = 0;
      m_pend = 0; m_null = 0; m_stat = 0; m_acc = 0; m_kind = 0; m_speed = 0; m_saddr = 0;
      for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      check_all("reset", 1'b0, frame_err);
      // R1: a quiet line produces nothing
      repeat (5) @(negedge clk);
      check_all("R1 idle line", 1'b0, frame_err);
      // R2: short bus request without stop, speed 010
      bus_req(3'b011, 3'b010, 1, -1, "R2 fair 7-bit");
      ev(1, 0, 0, 0, 0, "R4 won clears");
      bus_req(3'b010, 3'b001, 0, -1, "R2 prio 8-bit");
      ev(0, 1, 0, 0, 0, "R4 lost clears");
      // R3: invalid speed still accepted
      bus_req(3'b000, 3'b011, 0, -1, "R3 bad speed");
      // R4: second request ignored
      bus_req(3'b001, 3'b100, 0, -1, "R4 ignored while pending");
      ev(0, 0, 1, 0, 0, "R4 bus reset clears");
      // R5: receive during the frame drops a fair request
      bus_req(3'b011, 3'b000, 0, 3, "R5 rx during frame");
      bus_req(3'b010, 3'b000, 0, -1, "R5 prio pending");
      ev(0, 0, 0, 1, 0, "R5 rx clears prio");
      // R6: isochronous survives lost and receive
      bus_req(3'b001, 3'b000, 1, -1, "R6 iso pending");
      ev(0, 1, 0, 0, 0, "R6 lost keeps iso");
      ev(0, 0, 0, 1, 0, "R6 rx keeps iso");
      // R7, R11: register write while a bus request pends
      wr_req(4'h9, 8'hA5, 0, "R11 write keeps bus request");
      rd_req(4'h9, "R7 read back");
      // R8: further reads ignored, bus reset keeps flag
      rd_req(4'h2, "R8 second read ignored");
      ev(0, 0, 1, 0, 0, "R8 bus reset keeps status");
      ev(0, 0, 0, 0, 1, "R8 done clears");
      // R9: acceleration control
      acc_req(1'b0, "R9 disable");
      ev(0, 0, 1, 0, 0, "R9 bus reset reenables");
      acc_req(1'b0, "R9 disable again");
      eaa_cfg = 0;
      ev(0, 0, 1, 0, 0, "R9 reset without cfg");
      bus_req(3'b001, 3'b000, 0, -1, "R9 iso without cfg");
      eaa_cfg = 1;
      ev(1, 0, 0, 0, 0, "R6 won clears iso");
      // R10: malformed frames
      wr_req(4'h9, 8'h3C, 1, "R10 bad stop");
      bad_type("R10 type 111");
      // Random mix
      for (int k = 0; k < 400; k++) begin
         int op;
         op = $urandom_range(0, 9);
         if ($urandom_range(0, 15) == 0) eaa_cfg = ~eaa_cfg;
         case (op)
            0, 1, 2: bus_req(3'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                             1'($urandom_range(0, 1)), -1, "R2 random bus");
            3: rd_req(4'($urandom_range(0, 15)), "R8 random read");
            4: wr_req(4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)),
                      ($urandom_range(0, 7) == 0), "R7 random write");
            5: acc_req(1'($urandom_range(0, 1)), "R9 random accel");
            6: bad_type("R10 random bad type");
            default: ev(($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                        ($urandom_range(0, 7) == 0), ($urandom_range(0, 3) == 0),
                        ($urandom_range(0, 2) == 0), "R4 random event");
         endcase
      end
      summary();
      $finish;
   end
endmodule